// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block arbitrates twelve peripheral interrupt request lines for a small 8-bit CPU. Each line is qualified by its own enable and carries a 2-bit programmable level. The levels sit in a bank of three 8-bit level registers that a plain write port can reach. Among the qualified requests the block picks the most urgent level. It breaks ties at that level by the lowest line number, and then offers the winner to the CPU. The offer carries the winner's index and the address of its vector-table entry: 0xFFFA minus twice the index. The block also raises a wake flag for the standby logic.

The CPU side is a valid/ready stream. `irq_valid_o` is the offer and `irq_ack_i` is the ready. A transfer (acceptance) happens on a clock edge where `irq_valid_o` and `irq_ack_i` are high and `handler_ret_i` is low. Interrupt requests are levels, not packets. While the CPU holds off by keeping `irq_ack_i` low, the offer is not frozen. It follows the request lines with one clock of latency, and it may change winner or drop. An acceptance loads the winner's level as the running level and pushes the previous running level onto a three-entry stack. `handler_ret_i` pops that stack. From then on, only requests strictly more urgent than the running handler are offered, so nesting never goes deeper than three.

Top module: `irq_level_arbiter`

## Requirements
- R1: Level register k (write address k, 0 to 2) holds the level field of request n = 4k+j in data bits [2j+1:2j]. A write with `lvl_wen_i` high at address 3 changes nothing. After reset every field is 2'b11.
- R2: Field encoding: 2'b00 and 2'b01 are both the most urgent level, 2'b10 is the middle level and 2'b11 is the least urgent level.
- R3: A request line is considered only when both its request and its enable are high. Lines 8, 9 and 11 are reserved and never win.
- R4: Among the considered requests, one at a more urgent level always wins over one at a less urgent level, whatever their indices.
- R5: Among considered requests at the same level, the lowest index wins.
- R6: While `irq_valid_o` is high, `irq_vector_o` equals 16'hFFFA minus 2 times `irq_idx_o`. While it is low, both outputs are zero.
- R7: The outputs are registered and reflect the inputs and state sampled at the previous clock edge. After reset all outputs are zero.
- R8: With no handler running, a request at any level can be offered. With a handler running, only requests strictly more urgent than the running level are offered. Others are held off until a return.
- R9: An acceptance makes the winner's level the running level and pushes the previous one. `irq_valid_o` is low in the following cycle. `irq_ack_i` while `irq_valid_o` is low has no effect.
- R10: `handler_ret_i` restores the most recently pushed running level. With no handler running it is ignored. When it coincides with `irq_ack_i`, the return is taken and the acknowledge is ignored.
- R11: `wake_o` is high in the cycle after any request was eligible under R3 and R8. An acceptance does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 12 | Request line per peripheral |
| irq_en_i | input | 12 | Per-line enable of the request output |
| lvl_wen_i | input | 1 | Level register write strobe |
| lvl_waddr_i | input | 2 | Level register index |
| lvl_wdata_i | input | 8 | Level register write data |
| irq_valid_o | output | 1 | Interrupt offered to the CPU |
| irq_ack_i | input | 1 | CPU accepts the offer (ready) |
| irq_idx_o | output | 4 | Index of the offered request |
| irq_vector_o | output | 16 | Vector-table address of the offered request |
| handler_ret_i | input | 1 | Running handler has returned |
| wake_o | output | 1 | Wake request for standby logic |

## Verification
Request, enable and level-register changes appear on `irq_valid_o`, `irq_idx_o`, `irq_vector_o` and `wake_o` one edge later. An acceptance clears the offer at the same edge that samples it. The new running level, whether from an acceptance or a return, shapes the offer one edge after that. The bench drives every input 1 ns after an edge. Its behavioural model advances on each edge using the inputs held across it, and its expected values are compared with the outputs 1 ns after every edge. That respects the one- and two-edge delays above without reading the design's internals.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Urgency rank: 0 is most urgent, 2 least urgent, 3 means no handler.
  typedef logic [1:0] rank_t;

  localparam rank_t RANK_IDLE = 2'd3;

  function automatic rank_t field_to_rank(input logic [1:0] fld);
    case (fld)
      2'b00, 2'b01: field_to_rank = 2'd0;
      2'b10:        field_to_rank = 2'd1;
      default:      field_to_rank = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs #(
  parameter int unsigned N_IRQ  = 12,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned NREG   = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wen_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [2*N_IRQ-1:0]   levels_o
);

  logic [NREG-1:0][REG_W-1:0] bank_q;
  logic [NREG*REG_W-1:0]      flat;
  logic                       hit;

  assign hit  = wen_i && ({1'b0, waddr_i} < (ADDR_W+1)'(NREG));
  assign flat = bank_q;
  assign levels_o = flat[2*N_IRQ-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '1;
    end else if (hit) begin
      bank_q[waddr_i] <= wdata_i;
    end
  end

  // R1: without an in-range write the level bank keeps its contents.
  assert_bank_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen_i && ({1'b0, waddr_i} < (ADDR_W+1)'(NREG))) |=> $stable(levels_o));

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_IRQ = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N_IRQ-1:0]   live_i,
  input  logic [2*N_IRQ-1:0] levels_i,
  input  rank_t              cur_rank_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output rank_t              win_rank_o
);

  rank_t            rank_a [N_IRQ];
  logic [N_IRQ-1:0] elig;

  generate
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
      assign rank_a[g] = field_to_rank(levels_i[2*g +: 2]);
      assign elig[g]   = live_i[g] && (rank_a[g] < cur_rank_i);
    end
  endgenerate

  // Ascending scan with strict compare keeps the lowest index on a tie.
  always_comb begin
    found_o    = 1'b0;
    win_idx_o  = '0;
    win_rank_o = RANK_IDLE;
    for (int i = 0; i < N_IRQ; i++) begin
      if (elig[i] && (rank_a[i] < win_rank_o)) begin
        found_o    = 1'b1;
        win_idx_o  = IDX_W'(i);
        win_rank_o = rank_a[i];
      end
    end
  end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_arb_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  rank_t push_rank_i,
  input  logic  pop_i,
  output rank_t cur_rank_o
);

  localparam int unsigned SP_W = $clog2(DEPTH + 1);

  rank_t           stk_q [DEPTH];
  rank_t           cur_q;
  logic [SP_W-1:0] sp_q;
  logic            can_pop;

  assign can_pop    = pop_i && (sp_q != '0);
  assign cur_rank_o = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RANK_IDLE;
      sp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= RANK_IDLE;
    end else if (can_pop) begin
      cur_q <= stk_q[SP_W'(sp_q - 1'b1)];
      sp_q  <= sp_q - 1'b1;
    end else if (push_i && (sp_q < SP_W'(DEPTH))) begin
      stk_q[sp_q] <= cur_q;
      cur_q       <= push_rank_i;
      sp_q        <= sp_q + 1'b1;
    end
  end

  // R8: only strictly more urgent levels nest, so the stack never overflows.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (sp_q < SP_W'(DEPTH)));

  assert_nest_urgent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> (push_rank_i < cur_q));

  // R10: a return moves back to a less urgent level.
  assert_return_relax_R10: assert property (@(posedge clk) disable iff (!rst_n)
    can_pop |=> (cur_q > $past(cur_q)));

  // R10: a return with no handler running leaves the level idle.
  assert_idle_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && sp_q == '0) |=> (cur_q == RANK_IDLE));

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_IRQ     = 12,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned DEPTH     = 3,
  parameter logic [15:0] VEC_BASE  = 16'hFFFA,
  parameter int unsigned VEC_STEP  = 2,
  parameter logic [11:0] USED_MASK = 12'h4FF,
  localparam int unsigned IDX_W    = $clog2(N_IRQ),
  localparam int unsigned FPR      = REG_W / 2,
  localparam int unsigned NREG     = (N_IRQ + FPR - 1) / FPR,
  localparam int unsigned ADDR_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic              lvl_wen_i,
  input  logic [ADDR_W-1:0] lvl_waddr_i,
  input  logic [REG_W-1:0]  lvl_wdata_i,
  output logic              irq_valid_o,
  input  logic              irq_ack_i,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic [15:0]       irq_vector_o,
  input  logic              handler_ret_i,
  output logic              wake_o
);

  logic [2*N_IRQ-1:0] levels;
  logic [N_IRQ-1:0]   live;
  rank_t              cur_rank;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  rank_t              win_rank;
  logic               accept;

  logic               valid_q;
  logic [IDX_W-1:0]   idx_q;
  logic [15:0]        vec_q;
  rank_t              rank_q;
  logic               wake_q;

  assign live   = irq_req_i & irq_en_i & USED_MASK[N_IRQ-1:0];
  assign accept = valid_q && irq_ack_i && !handler_ret_i;

  irq_level_regs #(
    .N_IRQ (N_IRQ),
    .REG_W (REG_W),
    .NREG  (NREG),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wen_i   (lvl_wen_i),
    .waddr_i (lvl_waddr_i),
    .wdata_i (lvl_wdata_i),
    .levels_o(levels)
  );

  irq_select #(
    .N_IRQ(N_IRQ),
    .IDX_W(IDX_W)
  ) u_select (
    .live_i    (live),
    .levels_i  (levels),
    .cur_rank_i(cur_rank),
    .found_o   (found),
    .win_idx_o (win_idx),
    .win_rank_o(win_rank)
  );

  irq_level_stack #(
    .DEPTH(DEPTH)
  ) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (accept),
    .push_rank_i(rank_q),
    .pop_i      (handler_ret_i),
    .cur_rank_o (cur_rank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      vec_q   <= '0;
      rank_q  <= RANK_IDLE;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= found;
      if (accept || !found) begin
        valid_q <= 1'b0;
        idx_q   <= '0;
        vec_q   <= '0;
        rank_q  <= RANK_IDLE;
      end else begin
        valid_q <= 1'b1;
        idx_q   <= win_idx;
        vec_q   <= VEC_BASE - 16'(VEC_STEP) * 16'(win_idx);
        rank_q  <= win_rank;
      end
    end
  end

  assign irq_valid_o  = valid_q;
  assign irq_idx_o    = idx_q;
  assign irq_vector_o = vec_q;
  assign wake_o       = wake_q;

  // Checker copy of the qualified request lines from the previous edge.
  logic [N_IRQ-1:0] live_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_seen_q <= '0;
    else        live_seen_q <= irq_req_i & irq_en_i;
  end

  // R3: an offered index was requested and enabled one edge earlier.
  assert_offer_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> live_seen_q[irq_idx_o]);

  // R3: a reserved line is never offered.
  assert_no_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> USED_MASK[irq_idx_o]);

  // R9: an acceptance withdraws the offer for one cycle.
  assert_accept_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ack_i && !handler_ret_i) |=> !irq_valid_o);

  // R11: any offer implies a wake request.
  assert_wake_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> wake_o);

endmodule

// File: tb/irq_level_arbiter_bench.sv
`timescale 1ns/1ps
module irq_level_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] req = '0;
  logic [11:0] en = '0;
  logic        wen = 1'b0;
  logic [1:0]  waddr = '0;
  logic [7:0]  wdata = '0;
  logic        ack = 1'b0;
  logic        ret = 1'b0;
  logic        valid;
  logic [3:0]  idx;
  logic [15:0] vec;
  logic        wake;

  always #2.5 clk = ~clk;

  irq_level_arbiter u_irq_level_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req_i    (req),
    .irq_en_i     (en),
    .lvl_wen_i    (wen),
    .lvl_waddr_i  (waddr),
    .lvl_wdata_i  (wdata),
    .irq_valid_o  (valid),
    .irq_ack_i    (ack),
    .irq_idx_o    (idx),
    .irq_vector_o (vec),
    .handler_ret_i(ret),
    .wake_o       (wake)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string tag   = "R7";

  // Behavioural reference model.
  int lvl [12];
  int cur;
  int stk [$];
  int m_valid, m_idx, m_vec, m_wake, m_rank;
  bit used [12] = '{1,1,1,1,1,1,1,1,0,0,1,0};

  function automatic int rank_of(int f);
    return (f <= 1) ? 0 : f - 1;
  endfunction

  task automatic model_reset();
    foreach (lvl[i]) lvl[i] = 3;
    cur = 3; stk.delete();
    m_valid = 0; m_idx = 0; m_vec = 0; m_wake = 0; m_rank = 3;
  endtask

  task automatic model_step();
    int best, widx, found, acc, old_rank;
    best = 3; widx = 0; found = 0;
    for (int i = 0; i < 12; i++) begin
      if (used[i] && req[i] && en[i] && rank_of(lvl[i]) < cur && rank_of(lvl[i]) < best) begin
        best = rank_of(lvl[i]); widx = i; found = 1;
      end
    end
    acc = m_valid && ack && !ret;
    old_rank = m_rank;
    if (acc || !found) begin
      m_valid = 0; m_idx = 0; m_vec = 0; m_rank = 3;
    end else begin
      m_valid = 1; m_idx = widx; m_vec = 'hFFFA - 2 * widx; m_rank = best;
    end
    m_wake = found;
    if (ret && stk.size() > 0) cur = stk.pop_back();
    else if (acc) begin stk.push_back(cur); cur = old_rank; end
    if (wen && waddr < 3)
      for (int k = 0; k < 4; k++) lvl[waddr*4 + k] = (wdata >> (2*k)) & 3;
  endtask

  task automatic chk(string t, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag, "irq_valid", valid, m_valid);
    chk(tag, "irq_idx", idx, m_idx);
    chk("R6", "irq_vector", vec, m_vec);
    chk("R11", "wake", wake, m_wake);
  endtask

  // Inputs are held across the next edge; outputs are checked 1 ns after it.
  task automatic step();
    @(posedge clk); #1;
    model_step();
    compare();
  endtask

  task automatic wr(int a, int d);
    wen = 1'b1; waddr = 2'(a); wdata = 8'(d);
    step();
    wen = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    tag = "R7";
    chk("R7", "reset valid", valid, 0);
    chk("R7", "reset vector", vec, 0);
    chk("R7", "reset wake", wake, 0);
    rst_n = 1'b1;
    step();

    // R3: enable gating and reserved lines.
    tag = "R3";
    req = 12'hFFF; en = '0; step();
    chk("R3", "no enable no offer", valid, 0);
    req = 12'hB00; en = 12'hFFF; step(); step();
    chk("R3", "reserved lines idle", valid, 0);

    // R5: equal default levels, lowest index wins.
    tag = "R5";
    req = 12'h028; en = 12'hFFF; step();
    chk("R5", "tie winner", idx, 3);

    // R6: vector for individual lines.
    tag = "R6";
    req = 12'h400; step();
    chk("R6", "vector line 10", vec, 'hFFE6);
    req = 12'h001; step();
    chk("R6", "vector line 0", vec, 'hFFFA);
    req = 12'h080; step();
    chk("R6", "vector line 7", vec, 'hFFEC);

    // R1/R2: field placement and encoding.
    tag = "R1";
    req = '0; step();
    wr(1, 8'hF7);                     // line 5 -> 01
    req = 12'h021; step();
    chk("R1", "line 5 raised", idx, 5);
    tag = "R2";
    wr(0, 8'hFC);                     // line 0 -> 00, same as 01
    step();
    chk("R2", "00 equals 01", idx, 0);
    tag = "R1";
    wr(3, 8'h00);                     // out of range, no effect
    req = 12'h021; step();
    chk("R1", "addr 3 ignored", idx, 0);

    // R4: urgency beats index.
    tag = "R4";
    wr(0, 8'hEF);                     // line 2 -> 10
    wr(1, 8'hFF);
    req = 12'h044; step();
    chk("R4", "middle beats least", idx, 2);

    // R8/R9/R10: nesting and returns.
    tag = "R8";
    wr(0, 8'hF7);                     // line 1 -> 01
    wr(1, 8'hFE);                     // line 4 -> 10, line 7 -> 11
    req = 12'h080; step();
    chk("R8", "idle accepts least", idx, 7);
    tag = "R9";
    ack = 1'b1; step(); ack = 1'b0;
    chk("R9", "offer cleared", valid, 0);
    tag = "R8";
    step();
    chk("R8", "same level held", valid, 0);
    tag = "R9";
    ack = 1'b1; step(); ack = 1'b0;   // ack with no offer ignored
    tag = "R8";
    req = 12'h090; step();
    chk("R8", "more urgent nests", idx, 4);
    ack = 1'b1; step(); ack = 1'b0;
    req = 12'h092; step();
    chk("R8", "most urgent nests", idx, 1);
    tag = "R10";
    ack = 1'b1; ret = 1'b1; step(); ack = 1'b0; ret = 1'b0;
    step(); step();
    chk("R10", "return beat ack", idx, 1);
    ack = 1'b1; step(); ack = 1'b0;
    req = '0;
    for (int i = 0; i < 5; i++) begin
      ret = 1'b1; step(); ret = 1'b0; step();
    end
    req = 12'h080; step();
    chk("R10", "idle after returns", idx, 7);

    // Random phase: R4/R5/R8/R9/R10/R11 against the model.
    tag = "R4 random";
    for (int c = 0; c < 3000; c++) begin
      req = 12'($urandom); en = 12'($urandom) | 12'h0F0;
      ack = ($urandom % 3) == 0;
      ret = ($urandom % 5) == 0;
      wen = ($urandom % 9) == 0;
      waddr = 2'($urandom); wdata = 8'($urandom);
      step();
    end
    wen = 1'b0; ack = 1'b0; ret = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule